// File: doc/BRIEF.md
# Static memory bus controller

This block runs accesses to four external static memory regions, each reached through its own chip-select line. Every region has an 8-bit setup word that sets how many bus cycles an access lasts, whether the region is timed synchronously or needs an address setup cycle first, whether it may be written, and how wide its data bus is. Software programs these words through a small register port. A guard register protects them: a fixed 16-bit key must be written to it before any setup word can change. Any other value written there closes the guard again.

On the memory side a requester presents a region index, an address, a direction and write data for one cycle while the block is idle. The block then drives the selected chip-select, the output-enable or write-enable strobe and the byte-lane enables. It holds them for the programmed length and pulses a ready flag on the last cycle. A write aimed at a region marked read-only touches no memory pin and ends at once with an error flag. The block also reports the data width of the region being accessed. Splitting accesses into narrower beats and driving tristate pins are left to the logic around it.

Top module: `smc_top`

## Requirements
- R1: After reset, setup word 0 reads 0xF2 (length code 15, setup-cycle timing, read-only, 32-bit), setup words 1 to 3 read 0x00, and the guard register at offset 0x20 reads 1 (closed).
- R2: Writing 0xA05F to offset 0x20 opens the guard, which then reads 0. Writing any other value closes it, which then reads 1.
- R3: While the guard is closed, register writes to offsets 0x00, 0x04, 0x08 and 0x0C leave the setup words unchanged. Reads of every register are allowed in any guard state.
- R4: While the guard is open, a register write to offset 4*n stores write-data bits [7:0] in setup word n. Bits [7:4] are the length code, bit 3 is the timing mode (1 synchronous), bit 2 is write permission (1 writable) and bits [1:0] are the width code.
- R5: An accepted access keeps its chip-select low (active) for the whole access. The strobe phase lasts min(code+2, 16) cycles for length code `code`. `req_ready` is high only on the final cycle.
- R6: In synchronous mode the strobe starts in the first cycle after acceptance. In setup-cycle mode (bit 3 = 0) one extra first cycle has chip-select low with both strobes high, so chip-select is low for min(code+2,16)+1 cycles.
- R7: A read drives `mem_oe_n` low and a write drives `mem_we_n` low during the strobe phase. The two are never low together.
- R8: A write to a region whose bit 2 is 0 drives no chip-select and no write-enable. In the first cycle after acceptance it raises `req_ready` and `req_err` together for one cycle.
- R9: During an access `acc_width` gives the region's width code, with code 3 reported as 2 (32-bit). `mem_be` enables one lane at address bits [1:0] for code 0, lanes 1:0 or 3:2 selected by address bit 1 for code 1, and all four lanes otherwise.
- R10: At most one chip-select is low at any time. `req_busy` is high from the cycle after acceptance through the ready cycle and low after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| req_valid | input | 1 | Access request, sampled while `req_busy` is low |
| req_cs | input | 2 | Region index |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 24 | Access byte address |
| req_wdata | input | 32 | Access write data |
| req_busy | output | 1 | Access in progress |
| req_ready | output | 1 | Final cycle of the access |
| req_err | output | 1 | Write refused because the region is read-only |
| acc_width | output | 2 | Data width code of the current access |
| mem_cs_n | output | 4 | Active-low chip-selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_addr | output | 24 | Latched access address |
| mem_wdata | output | 32 | Latched write data |
| mem_be | output | 4 | Byte-lane enables |

## Verification
The assertions assume the requester raises `req_valid` only while `req_busy` is low and keeps it up for a single cycle. They also assume register writes use 4-byte-aligned offsets. The bench issues each request from a task that starts it in an idle cycle and drops it one cycle later. Setup words are always rewritten between accesses, never during one, and only aligned offsets are used. Under these conditions the one-hot chip-select, strobe exclusivity and held chip-select properties have no overlapping accesses that could break them.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef struct packed {
    logic [3:0] len_code;
    logic       sync_mode;
    logic       wr_allow;
    logic [1:0] width;
  } smc_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_XFER  = 2'd2,
    ST_FAULT = 2'd3
  } smc_state_e;

  localparam logic [15:0] GUARD_KEY   = 16'hA05F;
  localparam logic [7:0]  CFG0_RESET  = 8'hF2;
  localparam int          MAX_CYCLES  = 16;
  localparam int          LEN_BIAS    = 2;

endpackage

// File: rtl/smc_cfg_regs.sv
module smc_cfg_regs
  import smc_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int RAW    = 6,
  parameter int RDW    = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RAW-1:0] reg_addr,
  input  logic [RDW-1:0] reg_wdata,
  input  logic           reg_we,
  output logic [RDW-1:0] reg_rdata,
  output smc_cfg_t       cfg_o [NUM_CS]
);

  localparam logic [RAW-1:0] GUARD_OFS = RAW'(32);

  smc_cfg_t cfg_q [NUM_CS];
  smc_cfg_t cfg_d [NUM_CS];
  logic     cfg_en [NUM_CS];
  logic     lock_q;
  logic     lock_d;
  logic     lock_en;

  // next-state logic
  always_comb begin
    lock_en = reg_we && (reg_addr == GUARD_OFS);
    lock_d  = (reg_wdata != GUARD_KEY);
    for (int i = 0; i < NUM_CS; i++) begin
      cfg_en[i] = reg_we && !lock_q && (reg_addr == RAW'(4 * i));
      cfg_d[i]  = smc_cfg_t'(reg_wdata[7:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b1;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cfg
    if (g == 0) begin : g_boot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cfg_q[g] <= smc_cfg_t'(CFG0_RESET);
        end else if (cfg_en[g]) begin
          cfg_q[g] <= cfg_d[g];
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cfg_q[g] <= '0;
        end else if (cfg_en[g]) begin
          cfg_q[g] <= cfg_d[g];
        end
      end
    end

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && lock_q) |=> $stable(cfg_q[g])); // R3

    assign cfg_o[g] = cfg_q[g];
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (reg_addr == RAW'(4 * i)) begin
        reg_rdata = RDW'(cfg_q[i]);
      end
    end
    if (reg_addr == GUARD_OFS) begin
      reg_rdata = RDW'(lock_q);
    end
  end

  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == GUARD_OFS && reg_wdata == GUARD_KEY) |=> !lock_q); // R2

  AST_OTHER_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == GUARD_OFS && reg_wdata != GUARD_KEY) |=> lock_q); // R2

endmodule

// File: rtl/smc_xfer.sv
module smc_xfer
  import smc_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int AW     = 24,
  parameter int DW     = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  smc_cfg_t                  cfg_i [NUM_CS],
  input  logic                      req_valid,
  input  logic [$clog2(NUM_CS)-1:0] req_cs,
  input  logic                      req_write,
  input  logic [AW-1:0]             req_addr,
  input  logic [DW-1:0]             req_wdata,
  output logic                      req_busy,
  output logic                      req_ready,
  output logic                      req_err,
  output logic [1:0]                acc_width,
  output logic [NUM_CS-1:0]         mem_cs_n,
  output logic                      mem_oe_n,
  output logic                      mem_we_n,
  output logic [AW-1:0]             mem_addr,
  output logic [DW-1:0]             mem_wdata,
  output logic [DW/8-1:0]           mem_be
);

  localparam int CSW   = $clog2(NUM_CS);
  localparam int LANES = DW / 8;
  localparam int OFSW  = $clog2(LANES);
  localparam int CNTW  = $clog2(MAX_CYCLES);

  smc_state_e      state_q, state_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            cnt_en;
  logic            cap_en;
  logic [CSW-1:0]  cs_q;
  logic            wr_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic [1:0]      width_q;
  smc_cfg_t        cfg_sel;
  logic [CNTW-1:0] last_idx;
  logic            active;
  logic            strobe;

  function automatic logic [LANES-1:0] lane_mask(logic [1:0] w, logic [OFSW-1:0] ofs);
    logic [OFSW-1:0] pair;
    pair = ofs;
    pair[0] = 1'b0;
    case (w)
      2'b00:   return LANES'(1) << ofs;
      2'b01:   return LANES'(3) << pair;
      default: return '1;
    endcase
  endfunction

  // next-state logic
  always_comb begin
    cfg_sel = cfg_i[req_cs];
    if (cfg_sel.len_code >= 4'(MAX_CYCLES - LEN_BIAS)) begin
      last_idx = CNTW'(MAX_CYCLES - 1);
    end else begin
      last_idx = CNTW'(cfg_sel.len_code) + CNTW'(LEN_BIAS - 1);
    end

    state_d = state_q;
    cnt_d   = cnt_q;
    cap_en  = 1'b0;
    cnt_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_en = 1'b1;
          cnt_en = 1'b1;
          cnt_d  = last_idx;
          if (req_write && !cfg_sel.wr_allow) begin
            state_d = ST_FAULT;
          end else if (cfg_sel.sync_mode) begin
            state_d = ST_XFER;
          end else begin
            state_d = ST_SETUP;
          end
        end
      end
      ST_SETUP: state_d = ST_XFER;
      ST_XFER: begin
        if (cnt_q == '0) begin
          state_d = ST_IDLE;
        end else begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      width_q <= 2'b00;
    end else if (cap_en) begin
      cs_q    <= req_cs;
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      width_q <= cfg_sel.width;
    end
  end

  // output decode
  always_comb begin
    active    = (state_q == ST_SETUP) || (state_q == ST_XFER);
    strobe    = (state_q == ST_XFER);
    mem_cs_n  = active ? ~(NUM_CS'(1) << cs_q) : '1;
    mem_oe_n  = !(strobe && !wr_q);
    mem_we_n  = !(strobe && wr_q);
    req_ready = (strobe && cnt_q == '0) || (state_q == ST_FAULT);
    req_err   = (state_q == ST_FAULT);
    req_busy  = (state_q != ST_IDLE);
    acc_width = (width_q == 2'b11) ? 2'b10 : width_q;
    mem_be    = active ? lane_mask(width_q, addr_q[OFSW-1:0]) : '0;
    mem_addr  = addr_q;
    mem_wdata = wdata_q;
  end

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n)); // R10

  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R7

  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !(&mem_cs_n)); // R5

  AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&mem_cs_n) && !req_ready) |=> $stable(mem_cs_n)); // R5

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready); // R5

  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (mem_we_n && (&mem_cs_n) && req_ready)); // R8

  AST_SETUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&mem_cs_n) && !$past(req_busy)) |-> (mem_oe_n && mem_we_n) || $past(cfg_sel.sync_mode)); // R6

endmodule

// File: rtl/smc_top.sv
module smc_top
  import smc_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int RAW    = 6,
  parameter int RDW    = 16,
  parameter int AW     = 24,
  parameter int DW     = 32
) (
  input  logic                      clk,
  input  logic                      rst_ni,
  input  logic [RAW-1:0]            reg_addr,
  input  logic [RDW-1:0]            reg_wdata,
  input  logic                      reg_we,
  output logic [RDW-1:0]            reg_rdata,
  input  logic                      req_valid,
  input  logic [$clog2(NUM_CS)-1:0] req_cs,
  input  logic                      req_write,
  input  logic [AW-1:0]             req_addr,
  input  logic [DW-1:0]             req_wdata,
  output logic                      req_busy,
  output logic                      req_ready,
  output logic                      req_err,
  output logic [1:0]                acc_width,
  output logic [NUM_CS-1:0]         mem_cs_n,
  output logic                      mem_oe_n,
  output logic                      mem_we_n,
  output logic [AW-1:0]             mem_addr,
  output logic [DW-1:0]             mem_wdata,
  output logic [DW/8-1:0]           mem_be
);

  logic [1:0] rst_sync_q;
  logic       rst_n;
  smc_cfg_t   cfg [NUM_CS];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n = rst_sync_q[1];

  smc_cfg_regs #(
    .NUM_CS (NUM_CS),
    .RAW    (RAW),
    .RDW    (RDW)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .cfg_o     (cfg)
  );

  smc_xfer #(
    .NUM_CS (NUM_CS),
    .AW     (AW),
    .DW     (DW)
  ) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_i     (cfg),
    .req_valid (req_valid),
    .req_cs    (req_cs),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_busy  (req_busy),
    .req_ready (req_ready),
    .req_err   (req_err),
    .acc_width (acc_width),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_be    (mem_be)
  );

endmodule

// File: tb/smc_top_test.sv
module smc_top_test;

  typedef struct packed {
    logic [7:0] cfg;
    logic [1:0] cs;
    logic       wr;
    logic [1:0] alo;
    logic [4:0] cyc;
    logic [4:0] stb;
    logic       err;
    logic [3:0] be;
    logic [1:0] w;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{8'h0C, 2'd1, 1'b0, 2'd2, 5'd2,  5'd2,  1'b0, 4'b0100, 2'b00},
    '{8'h0D, 2'd2, 1'b1, 2'd3, 5'd2,  5'd2,  1'b0, 4'b1100, 2'b01},
    '{8'h30, 2'd3, 1'b0, 2'd1, 5'd6,  5'd5,  1'b0, 4'b0010, 2'b00},
    '{8'hE6, 2'd1, 1'b1, 2'd0, 5'd17, 5'd16, 1'b0, 4'b1111, 2'b10},
    '{8'hFB, 2'd2, 1'b0, 2'd2, 5'd16, 5'd16, 1'b0, 4'b1111, 2'b10},
    '{8'h10, 2'd1, 1'b1, 2'd0, 5'd0,  5'd0,  1'b1, 4'b0000, 2'b00},
    '{8'h29, 2'd3, 1'b0, 2'd1, 5'd4,  5'd4,  1'b0, 4'b0011, 2'b01},
    '{8'h1E, 2'd0, 1'b1, 2'd2, 5'd3,  5'd3,  1'b0, 4'b1111, 2'b10}
  };

  logic        clk;
  logic        rst_ni;
  logic [5:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        reg_we;
  logic [15:0] reg_rdata;
  logic        req_valid;
  logic [1:0]  req_cs;
  logic        req_write;
  logic [23:0] req_addr;
  logic [31:0] req_wdata;
  logic        req_busy;
  logic        req_ready;
  logic        req_err;
  logic [1:0]  acc_width;
  logic [3:0]  mem_cs_n;
  logic        mem_oe_n;
  logic        mem_we_n;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;

  int nchk;
  int nfail;

  smc_top uut (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .req_valid (req_valid),
    .req_cs    (req_cs),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_busy  (req_busy),
    .req_ready (req_ready),
    .req_err   (req_err),
    .acc_width (acc_width),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_be    (mem_be)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic reg_read(logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic run_access(int k);
    int   cs_cnt;
    int   stb_cnt;
    int   other_cnt;
    int   rdy_at;
    logic err_seen;
    logic [3:0] be_s;
    logic [1:0] w_s;
    logic busy_s;
    vec_t v;
    v = VEC[k];
    cs_cnt = 0; stb_cnt = 0; other_cnt = 0; rdy_at = 0; err_seen = 1'b0;
    be_s = '0; w_s = '0; busy_s = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    req_cs    = v.cs;
    req_write = v.wr;
    req_addr  = {22'h0A5A5A, v.alo};
    req_wdata = 32'hC0DE0000 + k;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (i == 1) begin
        be_s   = mem_be;
        w_s    = acc_width;
        busy_s = req_busy;
      end
      if (mem_cs_n[v.cs] == 1'b0) cs_cnt++;
      if ((mem_cs_n | (4'b0001 << v.cs)) != 4'b1111) other_cnt++;
      if (v.wr ? !mem_we_n : !mem_oe_n) stb_cnt++;
      if (req_err) err_seen = 1'b1;
      if (req_ready) begin
        rdy_at = i;
        break;
      end
    end
    check("R5 R6", "chip-select cycles", cs_cnt, v.cyc);
    check("R6 R7", "strobe cycles", stb_cnt, v.stb);
    check("R5", "ready cycle", rdy_at, v.err ? 1 : v.cyc);
    check("R8", "error flag", err_seen, v.err);
    check("R10", "other chip-selects", other_cnt, 0);
    check("R10", "busy in first cycle", busy_s, 1'b1);
    if (!v.err) begin
      check("R9", "byte lanes", be_s, v.be);
      check("R9", "width report", w_s, v.w);
    end
    @(negedge clk);
    check("R10", "busy after ready", req_busy, 1'b0);
  endtask

  initial begin
    logic [15:0] rd;
    nchk = 0;
    nfail = 0;
    rst_ni = 1'b0;
    reg_addr = '0; reg_wdata = '0; reg_we = 1'b0;
    req_valid = 1'b0; req_cs = '0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    reg_read(6'h00, rd); check("R1", "cfg0 reset", rd, 16'h00F2);
    reg_read(6'h04, rd); check("R1", "cfg1 reset", rd, 16'h0000);
    reg_read(6'h08, rd); check("R1", "cfg2 reset", rd, 16'h0000);
    reg_read(6'h0C, rd); check("R1", "cfg3 reset", rd, 16'h0000);
    reg_read(6'h20, rd); check("R1", "guard reset", rd, 16'h0001);
    check("R1", "pins idle", {mem_cs_n, mem_oe_n, mem_we_n, req_busy}, 7'b1111110);

    // R3 closed guard ignores writes
    reg_write(6'h04, 16'h005A);
    reg_read(6'h04, rd); check("R3", "locked write ignored", rd, 16'h0000);
    // R2 key opens
    reg_write(6'h20, 16'hA05F);
    reg_read(6'h20, rd); check("R2", "guard open", rd, 16'h0000);
    // R4 open write lands
    reg_write(6'h04, 16'hFF5A);
    reg_read(6'h04, rd); check("R4", "open write stored", rd, 16'h005A);
    // R2 other value closes
    reg_write(6'h20, 16'hA05E);
    reg_read(6'h20, rd); check("R2", "guard closed by near key", rd, 16'h0001);
    reg_write(6'h04, 16'h0033);
    reg_read(6'h04, rd); check("R3", "write after reclose ignored", rd, 16'h005A);
    reg_write(6'h00, 16'h0000);
    reg_read(6'h00, rd); check("R3", "cfg0 kept while locked", rd, 16'h00F2);

    // table walk
    for (int k = 0; k < NV; k++) begin
      reg_write(6'h20, 16'hA05F);
      reg_write({2'b00, VEC[k].cs, 2'b00}, {8'h00, VEC[k].cfg});
      reg_write(6'h20, 16'h0000);
      reg_read({2'b00, VEC[k].cs, 2'b00}, rd);
      check("R4", "setup readback", rd, {8'h00, VEC[k].cfg});
      run_access(k);
    end

    // R8: protected write leaves pins idle even on back-to-back attempt
    run_access(5);
    run_access(5);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    nfail++;
    $display("FAIL watchdog R5: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule